// File: doc/BRIEF.md
# Temperature Conversion Mode Sequencer

This block schedules the conversion cycles of a digital temperature sensor front end and turns each raw converter sample into the stored temperature word. A small configuration register picks one of four scheduling modes: free-running, single conversion on request, one conversion per second with the converter idle in between, or stopped. The same register picks the result resolution. All conversion windows are counted in milliseconds. A prescaler divides the system clock into milliseconds, and a parameter sets how many clock cycles make one millisecond.

Toward the converter, the block raises a one-cycle start pulse and holds a busy level for the whole window. In the last busy cycle it takes the sample the converter presents. It then writes the sample into the temperature register as a 16-bit two's-complement word and raises a one-cycle valid strobe. The analog sensing, the host serial port and any limit comparison live outside this block.

Top module: `tconv_sequencer`

## Requirements
- R1: While reset is held, `conv_start`, `conv_busy` and `temp_valid` are 0 and `temp_word` is 0.
- R2: The first conversion after reset lasts FAST_MS milliseconds. It is measured from the cycle `conv_start` is seen to the cycle `temp_valid` is seen, which is FAST_MS*TICKS_PER_MS cycles. In free-running mode it starts without any request.
- R3: In free-running mode (mode field `cfg_wdata[1:0]` = 2'b00) every later conversion lasts NORMAL_MS milliseconds. The next `conv_start` is high in the same cycle as the previous `temp_valid`.
- R4: In single mode (mode 2'b01) no conversion starts without a request. A pulse on `oneshot_req` gives `conv_start` in the following cycle and one conversion of NORMAL_MS. After that conversion the block stays idle.
- R5: In once-per-second mode (mode 2'b10) each conversion lasts SPS_MS. The next `conv_start` comes PERIOD_MS*TICKS_PER_MS cycles after the previous one, and `conv_busy` is low in between.
- R6: In stopped mode (mode 2'b11) no conversion starts and `temp_word` keeps its last value.
- R7: After reset the resolution is 13 bits. Writing `cfg_wdata[7]` = 1 selects 16 bits. The resolution in force at a conversion's start applies to its result.
- R8: At 13 bits the stored word is the sample with bits [2:0] forced to 0. At 16 bits the stored word is the sample unchanged. The sample is taken in the last busy cycle.
- R9: A mode change during a conversion does not cut the conversion short. It finishes with the length of its own mode, stores its result, and only then does the new mode decide what follows.
- R10: `temp_valid` is high for exactly one cycle per stored result, and `temp_word` changes only in a cycle where `temp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration: [1:0] mode, [7] high resolution |
| oneshot_req | input | 1 | Request pulse for a single conversion |
| adc_sample | input | 16 | Raw two's-complement sample from the converter |
| conv_start | output | 1 | One-cycle pulse on the first cycle of a conversion |
| conv_busy | output | 1 | High for the whole conversion window |
| temp_word | output | 16 | Stored temperature word |
| temp_valid | output | 1 | One-cycle strobe marking a new stored word |

## Verification
The bench times every conversion from start pulse to valid strobe. A design that forgot the short first window, or kept using it, would show a window length that is off by whole milliseconds. A resolution change written during a conversion, and a switch to stopped mode written during a conversion, both test that settings are taken at conversion boundaries. A design that honoured them at once would truncate the wrong result, or would cut the conversion short and lose its store. The once-per-second checks measure start-to-start spacing and watch that busy stays low in the rest interval, which catches a period counted from the end of the conversion instead of its start. A random mix of mode and resolution changes exercises every transition between back-to-back and duty-cycled scheduling.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'b00,
    MODE_SINGLE  = 2'b01,
    MODE_PERIOD  = 2'b10,
    MODE_STOP    = 2'b11
  } tcs_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CONV = 2'b01,
    ST_REST = 2'b10
  } tcs_state_e;

  localparam int CFG_MODE_LSB = 0;
  localparam int CFG_RES_BIT  = 7;

endpackage

// File: rtl/tcs_rst_sync.sv
module tcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tcs_cfg_reg.sv
module tcs_cfg_reg
  import tcs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [7:0] wr_data,
  output tcs_mode_e mode,
  output logic      hi_res
);

  tcs_mode_e mode_q, mode_d;
  logic      res_q,  res_d;
  logic      unused_cfg_bits;

  assign unused_cfg_bits = ^wr_data[6:2];

  always_comb begin
    mode_d = mode_q;
    res_d  = res_q;
    if (wr_en) begin
      mode_d = tcs_mode_e'(wr_data[CFG_MODE_LSB +: 2]);
      res_d  = wr_data[CFG_RES_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      res_q  <= 1'b0;
    end else if (wr_en) begin
      mode_q <= mode_d;
      res_q  <= res_d;
    end
  end

  assign mode   = mode_q;
  assign hi_res = res_q;

  // R7: without a write the resolution bit never moves
  a_r7_res_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(res_q));

endmodule

// File: rtl/tcs_window_timer.sv
module tcs_window_timer #(
  parameter int TICKS_PER_MS = 125000,
  parameter int MS_W         = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [MS_W-1:0] len_ms,
  output logic            expire
);

  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

  logic            ms_tick;
  logic [MS_W-1:0] ms_q, ms_d;

  generate
    if (TICKS_PER_MS == 1) begin : g_no_div
      assign ms_tick = 1'b1;
    end else begin : g_div
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_wrap;

      assign pre_wrap = (pre_q == PRE_W'(TICKS_PER_MS - 1));
      assign ms_tick  = pre_wrap;

      always_comb begin
        if (clr)           pre_d = '0;
        else if (pre_wrap) pre_d = '0;
        else               pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      // R2: the prescaler restarts from zero at every window start
      a_r2_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));
    end
  endgenerate

  assign expire = ms_tick && (ms_q == (len_ms - 1'b1));

  always_comb begin
    if (clr)          ms_d = '0;
    else if (ms_tick) ms_d = ms_q + 1'b1;
    else              ms_d = ms_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ms_q <= '0;
    else if (clr || ms_tick) ms_q <= ms_d;
  end

endmodule

// File: rtl/tcs_mode_fsm.sv
module tcs_mode_fsm
  import tcs_pkg::*;
#(
  parameter int FAST_MS   = 6,
  parameter int NORMAL_MS = 240,
  parameter int SPS_MS    = 60,
  parameter int PERIOD_MS = 1000,
  parameter int MS_W      = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tcs_mode_e       mode,
  input  logic            hi_res,
  input  logic            oneshot_req,
  input  logic            expire,
  output logic            timer_clr,
  output logic [MS_W-1:0] len_ms,
  output logic            start,
  output logic            busy,
  output logic            capture,
  output logic            res_used
);

  tcs_state_e      state_q, state_d;
  logic [MS_W-1:0] len_q, len_d;
  logic [MS_W-1:0] clen_q, clen_d;
  logic [MS_W-1:0] new_len;
  logic            first_q, first_d;
  logic            pend_q, pend_d;
  logic            res_q, res_d;
  logic            start_q;
  logic            go, rest, want, req_any;

  assign req_any = pend_q || (oneshot_req && (mode == MODE_SINGLE));
  assign want    = (mode == MODE_RUN) || (mode == MODE_PERIOD) ||
                   ((mode == MODE_SINGLE) && req_any);

  always_comb begin
    if (first_q)                  new_len = MS_W'(FAST_MS);
    else if (mode == MODE_PERIOD) new_len = MS_W'(SPS_MS);
    else                          new_len = MS_W'(NORMAL_MS);
  end

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    clen_d  = clen_q;
    first_d = first_q;
    res_d   = res_q;
    go      = 1'b0;
    rest    = 1'b0;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: go = want;
      ST_CONV: begin
        if (expire) begin
          capture = 1'b1;
          if (mode == MODE_PERIOD) rest = 1'b1;
          else if (want)           go   = 1'b1;
          else                     state_d = ST_IDLE;
        end
      end
      ST_REST: begin
        if (mode != MODE_PERIOD) state_d = ST_IDLE;
        else if (expire)         go      = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (rest) begin
      state_d = ST_REST;
      len_d   = MS_W'(PERIOD_MS) - clen_q;
    end
    if (go) begin
      state_d = ST_CONV;
      len_d   = new_len;
      clen_d  = new_len;
      first_d = 1'b0;
      res_d   = hi_res;
    end
    pend_d = (mode == MODE_SINGLE) ? (req_any && !go) : 1'b0;
  end

  assign timer_clr = go || rest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b1;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
      pend_q  <= pend_d;
      start_q <= go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      clen_q <= '0;
      res_q  <= 1'b0;
    end else if (go || rest) begin
      len_q  <= len_d;
      clen_q <= clen_d;
      res_q  <= res_d;
    end
  end

  assign len_ms   = len_q;
  assign start    = start_q;
  assign busy     = (state_q == ST_CONV);
  assign res_used = res_q;

  // R6: stopped mode never launches from idle
  a_r6_stop_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && mode == MODE_STOP) |=> !start_q);

  // R4: single mode without a pending request stays idle
  a_r4_single_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && mode == MODE_SINGLE && !pend_q && !oneshot_req) |=> !start_q);

  // R9: a conversion is never abandoned before its window expires
  a_r9_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && !expire) |=> (state_q == ST_CONV));

  // R5: the rest interval is only entered from a finished conversion
  a_r5_rest_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_REST) |-> $past(state_q == ST_CONV));

endmodule

// File: rtl/tcs_result_reg.sv
module tcs_result_reg #(
  parameter int DATA_W      = 16,
  parameter int LO_RES_BITS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              hi_res,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] temp,
  output logic              valid
);

  localparam int DROP = DATA_W - LO_RES_BITS;

  logic [DATA_W-1:0] fmt;
  logic [DATA_W-1:0] temp_q;
  logic              valid_q;
  logic              hres_q;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      if (gi < DROP) begin : g_lo
        assign fmt[gi] = hi_res & sample[gi];
      end else begin : g_hi
        assign fmt[gi] = sample[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      hres_q <= 1'b0;
    end else if (capture) begin
      temp_q <= fmt;
      hres_q <= hi_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= capture;
  end

  assign temp  = temp_q;
  assign valid = valid_q;

  // R8: a coarse result carries zeros below its LSB
  a_r8_coarse_lsbs: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !hres_q) |-> (temp_q[DROP-1:0] == '0));

  // R10: no store without capture, and the strobe lasts one cycle
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(temp_q));
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

endmodule

// File: rtl/tconv_sequencer.sv
module tconv_sequencer
  import tcs_pkg::*;
#(
  parameter int TICKS_PER_MS = 125000,
  parameter int FAST_MS      = 6,
  parameter int NORMAL_MS    = 240,
  parameter int SPS_MS       = 60,
  parameter int PERIOD_MS    = 1000,
  parameter int DATA_W       = 16,
  parameter int LO_RES_BITS  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              oneshot_req,
  input  logic [DATA_W-1:0] adc_sample,
  output logic              conv_start,
  output logic              conv_busy,
  output logic [DATA_W-1:0] temp_word,
  output logic              temp_valid
);

  localparam int MS_W = $clog2(PERIOD_MS + 1);

  logic            rst_i_n;
  tcs_mode_e       mode;
  logic            hi_res;
  logic            expire, timer_clr, capture, res_used;
  logic [MS_W-1:0] len_ms;

  tcs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  tcs_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .mode    (mode),
    .hi_res  (hi_res)
  );

  tcs_window_timer #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .MS_W         (MS_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .clr    (timer_clr),
    .len_ms (len_ms),
    .expire (expire)
  );

  tcs_mode_fsm #(
    .FAST_MS   (FAST_MS),
    .NORMAL_MS (NORMAL_MS),
    .SPS_MS    (SPS_MS),
    .PERIOD_MS (PERIOD_MS),
    .MS_W      (MS_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .mode        (mode),
    .hi_res      (hi_res),
    .oneshot_req (oneshot_req),
    .expire      (expire),
    .timer_clr   (timer_clr),
    .len_ms      (len_ms),
    .start       (conv_start),
    .busy        (conv_busy),
    .capture     (capture),
    .res_used    (res_used)
  );

  tcs_result_reg #(
    .DATA_W      (DATA_W),
    .LO_RES_BITS (LO_RES_BITS)
  ) u_result (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .capture (capture),
    .hi_res  (res_used),
    .sample  (adc_sample),
    .temp    (temp_word),
    .valid   (temp_valid)
  );

  // R6: while stopped and not converting, the stored word is frozen
  a_r6_stop_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode == MODE_STOP && !conv_busy) |=> $stable(temp_word));

  // R3: a start pulse always opens a busy window
  a_r3_start_in_window: assert property (@(posedge clk) disable iff (!rst_i_n)
    conv_start |-> conv_busy);

endmodule

// File: tb/tconv_sequencer_bench.sv
module tconv_sequencer_bench;

  localparam int TPM    = 4;
  localparam int FAST   = 3;
  localparam int NORMAL = 24;
  localparam int SPS    = 10;
  localparam int PERIOD = 50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic        oneshot_req;
  logic [15:0] adc_sample;
  logic        conv_start, conv_busy, temp_valid;
  logic [15:0] temp_word;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int mon_err = 0;
  bit mon_on = 0;
  logic [15:0] prev_temp;
  logic        prev_valid;

  always #4 clk = ~clk;

  tconv_sequencer #(
    .TICKS_PER_MS (TPM),
    .FAST_MS      (FAST),
    .NORMAL_MS    (NORMAL),
    .SPS_MS       (SPS),
    .PERIOD_MS    (PERIOD)
  ) u_tconv_sequencer (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .oneshot_req (oneshot_req),
    .adc_sample  (adc_sample),
    .conv_start  (conv_start),
    .conv_busy   (conv_busy),
    .temp_word   (temp_word),
    .temp_valid  (temp_valid)
  );

  function automatic logic [15:0] fmt(input logic [15:0] s, input bit hi);
    return hi ? s : {s[15:3], 3'b000};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // R10 monitor: word changes only with the strobe, strobe never doubles
  always @(negedge clk) begin
    if (mon_on) begin
      if (temp_word != prev_temp && !temp_valid) mon_err++;
      if (temp_valid && prev_valid) mon_err++;
    end
    prev_temp  <= temp_word;
    prev_valid <= temp_valid;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "WDOG", "watchdog expired", cyc, 150000);
      finish_run();
    end
  end

  task automatic cfg_write(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_start(input int max, output int n);
    n = 0;
    while (!conv_start && n < max) begin
      @(negedge clk); n++;
    end
  endtask

  // Called at the negedge where conv_start is seen; returns at the valid negedge
  task automatic run_conv(input int ms, input bit hi, input string req,
                          input bit do_wr, input logic [7:0] wv);
    logic [15:0] s;
    int n;
    s = 16'($urandom);
    adc_sample = s;
    if (do_wr) begin cfg_we = 1'b1; cfg_wdata = wv; end
    n = 0;
    do begin
      @(negedge clk); cfg_we = 1'b0; n++;
    end while (!temp_valid && n < 20000);
    chk(n == ms * TPM, req, "window length", n, ms * TPM);
    chk(temp_word == fmt(s, hi), "R8", "stored word", int'(temp_word), int'(fmt(s, hi)));
  endtask

  task automatic quiet(input int len, input string req);
    int starts = 0, busys = 0, vals = 0;
    logic [15:0] t0;
    t0 = temp_word;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (conv_start) starts++;
      if (conv_busy)  busys++;
      if (temp_valid) vals++;
    end
    chk(starts == 0 && busys == 0 && vals == 0, req, "idle activity",
        starts + busys + vals, 0);
    chk(temp_word == t0, req, "word held", int'(temp_word), int'(t0));
  endtask

  initial begin
    int n;
    int cur_len;
    bit cur_per, cur_hi, new_per, new_hi;
    void'($urandom(32'h5EED_2024));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00; oneshot_req = 1'b0;
    adc_sample = 16'h0000;
    repeat (3) @(negedge clk);
    chk(!conv_start && !conv_busy && !temp_valid && temp_word == 16'h0,
        "R1", "reset outputs", int'(temp_word), 0);
    rst_n = 1'b1;
    mon_on = 1;

    // R2: fast first conversion, default 13-bit (R7)
    wait_start(20, n);
    chk(conv_start, "R2", "first start after reset", n, 0);
    run_conv(FAST, 0, "R2", 0, 8'h00);
    // R3: back-to-back normal conversions
    for (int i = 0; i < 2; i++) begin
      chk(conv_start, "R3", "start with valid", conv_start, 1);
      run_conv(NORMAL, 0, "R3", 0, 8'h00);
    end
    // R7: resolution change mid-conversion takes effect on the next one
    chk(conv_start, "R3", "start with valid", conv_start, 1);
    run_conv(NORMAL, 0, "R7", 1, 8'h80);
    chk(conv_start, "R3", "start with valid", conv_start, 1);
    run_conv(NORMAL, 1, "R7", 0, 8'h00);
    // R9 + R6: switch to stopped during a conversion
    chk(conv_start, "R3", "start with valid", conv_start, 1);
    run_conv(NORMAL, 1, "R9", 1, 8'h83);
    chk(!conv_start, "R9", "no restart after stop", conv_start, 0);
    quiet(300, "R6");

    // R4: single mode
    cfg_write(8'h81);
    quiet(100, "R4");
    for (int k = 0; k < 2; k++) begin
      oneshot_req = 1'b1;
      @(negedge clk);
      oneshot_req = 1'b0;
      chk(conv_start, "R4", "start after request", conv_start, 1);
      run_conv(NORMAL, 1, "R4", 0, 8'h00);
      quiet(150, "R4");
    end

    // R5: once-per-period mode
    cfg_write(8'h82);
    wait_start(20, n);
    chk(conv_start, "R5", "periodic start", n, 0);
    for (int k = 0; k < 2; k++) begin
      int busy_seen = 0;
      run_conv(SPS, 1, "R5", 0, 8'h00);
      n = 0;
      while (!conv_start && n < 20000) begin
        @(negedge clk); n++;
        if (conv_busy && !conv_start) busy_seen++;
      end
      chk(n == (PERIOD - SPS) * TPM, "R5", "rest length", n, (PERIOD - SPS) * TPM);
      chk(busy_seen == 0, "R5", "busy during rest", busy_seen, 0);
    end

    // Random mode/resolution changes written at conversion starts
    cur_per = 1; cur_hi = 1;
    for (int k = 0; k < 10; k++) begin
      new_per = 1'($urandom);
      new_hi  = 1'($urandom);
      cur_len = cur_per ? SPS : NORMAL;
      run_conv(cur_len, cur_hi, cur_per ? "R5" : "R3", 1,
               {new_hi, 5'b0, new_per, 1'b0});
      if (!new_per) begin
        chk(conv_start, "R9", "next start follows new mode", conv_start, 1);
      end else begin
        n = 0;
        while (!conv_start && n < 20000) begin @(negedge clk); n++; end
        chk(n == (PERIOD - cur_len) * TPM, "R9", "rest after switch", n,
            (PERIOD - cur_len) * TPM);
      end
      cur_per = new_per; cur_hi = new_hi;
    end

    chk(mon_err == 0, "R10", "strobe/word monitor", mon_err, 0);
    finish_run();
  end

endmodule